// File: doc/BRIEF.md
# DMA Channel Completion Result and Interrupt Reporter

This block sits between a set of DMA transfer engines and the processor that drives them. Each engine signals the end of a command list with a one-cycle done pulse. The pulse carries three indications: the transfer failed, the transfer was flushed, and the last command completed. The reporter stores that outcome as a result word for the channel. It tracks whether a result is waiting and raises a per-channel pending bit when software has enabled interrupts for that kind of outcome. A single level-sensitive interrupt line is the OR of all pending bits.

Software works through a small register bus. A read of a channel's result word returns the oldest stored outcome and removes it in the same cycle. The status word shows whether one or two results are held. A per-channel configuration word enables interrupts separately for normal completions and for flushed completions. A summary word lists the pending bit of every channel. Each channel holds one further result behind the one being reported. Any arrival beyond that is dropped, and the drop is marked as an error on the waiting entry.

The done inputs are plain pulses and cannot be stalled. The register bus has no ready signal and accepts one access per cycle. A read is answered on `rd_valid`/`rd_data` exactly one cycle later, and that answer cannot be held off. Writes produce no response.

Top module: `dma_result_irq`

## Requirements
- R1: After reset no channel holds a result, every configuration word reads 0 (all interrupts masked), `irq_pend` is 0 and `irq_o` is low.
- R2: The result word of channel i is read at byte address 0x040 + 4*i. Bit 31 means a result is held, bit 3 means error, bit 2 means flushed and bit 1 means last command done. All other bits are 0. The word is all zeros when nothing is held.
- R3: A read of a channel's result word removes the reported result. If a second result was waiting, it becomes the reported one. Otherwise the channel's status present bit and its pending bit clear.
- R4: The status word of channel i is read at 0x0C0 + 4*i. Bit 1 means at least one result is held and bit 2 means a second result is waiting. Reading it changes nothing.
- R5: The configuration word of channel i is at 0x100 + 4*i. Bit 0 enables interrupts for non-flushed results and bit 1 enables them for flushed results. It reads back as written (bits 1:0). Writing 0 masks the channel without discarding its held result.
- R6: Pending bit i (port `irq_pend[i]`, and bit i of the summary word at 0x180) is set while channel i holds a result and the matching enable is set. Bit 1 is the matching enable when the reported result is flushed, and bit 0 otherwise.
- R7: `irq_o` is high exactly when any pending bit is set. It stays high until the pending results are read or masked.
- R8: Each channel holds at most two results. A done pulse arriving while two are held is dropped, and the waiting (second) result gets its error bit set.
- R9: A done pulse in the same cycle as a read of that channel's result word: the read returns the older result, and the new outcome is stored afterwards.
- R10: Every read returns `rd_valid` high with its data exactly one cycle after the request. `rd_valid` is low in all other cycles. Unmapped addresses read 0. Writes to any address other than a configuration word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_done | input | NUM_CH | Per-channel completion pulse |
| ch_err | input | NUM_CH | Error indication, sampled with ch_done |
| ch_flush | input | NUM_CH | Flushed indication, sampled with ch_done |
| ch_last | input | NUM_CH | Last-command indication, sampled with ch_done |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | 32 | Read data |
| irq_pend | output | NUM_CH | Per-channel pending bits |
| irq_o | output | 1 | Level interrupt, OR of pending bits |

## Verification
The assertions check the following on every cycle:
- each read gets a response one cycle later, and no response appears otherwise;
- a pending bit or the interrupt line only ever appears while a result is held;
- a done pulse always leaves a held result in the next cycle;
- a held result disappears only on a read of that channel's result word.

The following can only be shown by the bench's scenarios, which compare against a queue-based reference model on every clock:
- the exact flag bits;
- the separate flush and normal enables;
- promotion of the waiting result;
- the error mark left by a dropped third arrival;
- ordering when a done pulse and a read hit the same channel together.

// File: rtl/dres_pkg.sv
package dres_pkg;

  // Flags captured from a done pulse
  typedef struct packed {
    logic err;
    logic flush;
    logic tpd;
  } dres_flags_t;

  // Register banks: address bits [ADDR_W-1:6] select the bank,
  // bits [5:2] select the channel.
  localparam int BANK_RESULT = 1;  // 0x040
  localparam int BANK_STATUS = 3;  // 0x0C0
  localparam int BANK_CONFIG = 4;  // 0x100
  localparam int BANK_SUMM   = 6;  // 0x180

  // Result word bit positions (decoded by software)
  localparam int RES_VALID_BIT = 31;
  localparam int RES_ERR_BIT   = 3;
  localparam int RES_FLUSH_BIT = 2;
  localparam int RES_TPD_BIT   = 1;

  // Status word bit positions
  localparam int STAT_PRESENT_BIT = 1;
  localparam int STAT_WAITING_BIT = 2;

  function automatic logic [31:0] result_word(input logic v, input dres_flags_t f);
    logic [31:0] w;
    w = '0;
    if (v) begin
      w[RES_VALID_BIT] = 1'b1;
      w[RES_ERR_BIT]   = f.err;
      w[RES_FLUSH_BIT] = f.flush;
      w[RES_TPD_BIT]   = f.tpd;
    end
    return w;
  endfunction

endpackage

// File: rtl/dres_chan.sv
module dres_chan
  import dres_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        done,
  input  dres_flags_t flags_in,
  input  logic        pop,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_wdata,
  output logic        head_v,
  output logic        tail_v,
  output dres_flags_t head_f,
  output logic [1:0]  cfg,
  output logic        pend
);

  dres_flags_t tail_f;
  logic        nh_v, nt_v;
  dres_flags_t nh_f, nt_f;

  // Pop first, then store any arrival in the first free slot
  always_comb begin
    nh_v = head_v;
    nh_f = head_f;
    nt_v = tail_v;
    nt_f = tail_f;
    if (pop) begin
      nh_v = tail_v;
      nh_f = tail_f;
      nt_v = 1'b0;
      nt_f = '0;
    end
    if (done) begin
      if (!nh_v) begin
        nh_v = 1'b1;
        nh_f = flags_in;
      end else if (!nt_v) begin
        nt_v = 1'b1;
        nt_f = flags_in;
      end else begin
        nt_f.err = 1'b1;   // overflow: mark the waiting entry
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_v <= 1'b0;
      tail_v <= 1'b0;
      head_f <= '0;
      tail_f <= '0;
      cfg    <= '0;
    end else begin
      head_v <= nh_v;
      tail_v <= nt_v;
      head_f <= nh_f;
      tail_f <= nt_f;
      if (cfg_we) cfg <= cfg_wdata;
    end
  end

  assign pend = head_v & (head_f.flush ? cfg[1] : cfg[0]);

endmodule

// File: rtl/dres_regs.sv
module dres_regs
  import dres_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  input  logic [NUM_CH-1:0]      head_v,
  input  logic [NUM_CH-1:0]      tail_v,
  input  logic [NUM_CH-1:0][2:0] head_f,
  input  logic [NUM_CH-1:0][1:0] cfg,
  input  logic [NUM_CH-1:0]      pend,
  output logic [NUM_CH-1:0]      pop,
  output logic [NUM_CH-1:0]      cfg_we,
  output logic [1:0]             cfg_wdata,
  output logic                   rd_valid,
  output logic [31:0]            rd_data
);

  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int BANK_W = ADDR_W - 6;

  logic [BANK_W-1:0] bank;
  logic [IDX_W-1:0]  ch;
  logic              hit;
  logic              rd_req, wr_req;
  logic [31:0]       rd_next;

  assign bank      = bus_addr[ADDR_W-1:6];
  assign ch        = bus_addr[2 +: IDX_W];
  assign hit       = ({1'b0, bus_addr[5:2]} < 5'(NUM_CH));
  assign rd_req    = bus_sel & ~bus_we;
  assign wr_req    = bus_sel & bus_we;
  assign cfg_wdata = bus_wdata[1:0];

  always_comb begin
    pop    = '0;
    cfg_we = '0;
    if (rd_req && hit && bank == BANK_W'(BANK_RESULT)) pop[ch]    = 1'b1;
    if (wr_req && hit && bank == BANK_W'(BANK_CONFIG)) cfg_we[ch] = 1'b1;
  end

  always_comb begin
    rd_next = '0;
    if (bank == BANK_W'(BANK_SUMM)) begin
      if (bus_addr[5:2] == 4'd0) rd_next[NUM_CH-1:0] = pend;
    end else if (hit) begin
      if (bank == BANK_W'(BANK_RESULT)) begin
        rd_next = result_word(head_v[ch], dres_flags_t'(head_f[ch]));
      end else if (bank == BANK_W'(BANK_STATUS)) begin
        rd_next[STAT_PRESENT_BIT] = head_v[ch];
        rd_next[STAT_WAITING_BIT] = tail_v[ch];
      end else if (bank == BANK_W'(BANK_CONFIG)) begin
        rd_next[1:0] = cfg[ch];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_next;
    end
  end

endmodule

// File: rtl/dma_result_irq.sv
module dma_result_irq
  import dres_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_done,
  input  logic [NUM_CH-1:0] ch_err,
  input  logic [NUM_CH-1:0] ch_flush,
  input  logic [NUM_CH-1:0] ch_last,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic [NUM_CH-1:0] irq_pend,
  output logic              irq_o
);

  logic [NUM_CH-1:0]      head_v, tail_v, pop_vec, cfg_we;
  logic [NUM_CH-1:0][2:0] head_f;
  logic [NUM_CH-1:0][1:0] cfg;
  logic [1:0]             cfg_wdata;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dres_flags_t fin, hf;
    assign fin = '{err: ch_err[i], flush: ch_flush[i], tpd: ch_last[i]};
    assign head_f[i] = hf;
    dres_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (ch_done[i]),
      .flags_in (fin),
      .pop      (pop_vec[i]),
      .cfg_we   (cfg_we[i]),
      .cfg_wdata(cfg_wdata),
      .head_v   (head_v[i]),
      .tail_v   (tail_v[i]),
      .head_f   (hf),
      .cfg      (cfg[i]),
      .pend     (irq_pend[i])
    );
  end

  dres_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .head_v   (head_v),
    .tail_v   (tail_v),
    .head_f   (head_f),
    .cfg      (cfg),
    .pend     (irq_pend),
    .pop      (pop_vec),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign irq_o = |irq_pend;

endmodule

// File: rtl/dres_chk.sv
module dres_chk #(
  parameter int NUM_CH = 16
)(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic              rd_valid,
  input logic              irq_o,
  input logic [NUM_CH-1:0] irq_pend,
  input logic [NUM_CH-1:0] ch_done,
  input logic [NUM_CH-1:0] head_v,
  input logic [NUM_CH-1:0] pop
);

  // R10
  rd_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we) |=> rd_valid);

  // R10
  rd_only_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> !rd_valid);

  // R7
  irq_needs_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (head_v != '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_c
    // R6
    pend_needs_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pend[i] |-> head_v[i]);

    // R8
    done_is_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_done[i] |=> head_v[i]);

    // R3
    held_until_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (head_v[i] && !pop[i]) |=> head_v[i]);
  end

endmodule

bind dma_result_irq dres_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_sel (bus_sel),
  .bus_we  (bus_we),
  .rd_valid(rd_valid),
  .irq_o   (irq_o),
  .irq_pend(irq_pend),
  .ch_done (ch_done),
  .head_v  (head_v),
  .pop     (pop_vec)
);

// File: tb/dma_result_irq_test.sv
module dma_result_irq_test;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  ch_done = '0, ch_err = '0, ch_flush = '0, ch_last = '0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          rd_valid, irq_o;
  logic [31:0]   rd_data;
  logic [N-1:0]  irq_pend;

  int n_checks = 0, n_fail = 0;
  bit model_on = 1'b0;

  always #5 clk = ~clk;

  dma_result_irq #(.NUM_CH(N), .ADDR_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .ch_done(ch_done), .ch_err(ch_err),
    .ch_flush(ch_flush), .ch_last(ch_last), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq_pend(irq_pend), .irq_o(irq_o));

  // Reference model: per-channel queue of {err,flush,last}
  logic [2:0]  mq [N][$];
  logic [1:0]  mcfg [N];
  logic        exp_rv = 1'b0;
  logic [31:0] exp_rd = '0;
  string       exp_tag = "R10";

  function automatic logic [N-1:0] model_pend();
    logic [N-1:0] p = '0;
    for (int c = 0; c < N; c++)
      if (mq[c].size() > 0)
        p[c] = mq[c][0][1] ? mcfg[c][1] : mcfg[c][0];
    return p;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < N; c++) begin mq[c].delete(); mcfg[c] = 2'b00; end
      exp_rv = 1'b0;
    end else begin
      int bank, idx;
      bank = int'(bus_addr) >> 6;
      idx  = (int'(bus_addr) >> 2) & 15;
      exp_rv = 1'b0;
      if (bus_sel && !bus_we) begin
        exp_rv = 1'b1;
        exp_rd = '0;
        exp_tag = "R10";
        case (bank)
          1: begin
            exp_tag = "R2";
            if (mq[idx].size() > 0) exp_rd = 32'h8000_0000 | (32'(mq[idx][0]) << 1);
          end
          3: begin
            exp_tag = "R4";
            exp_rd = (mq[idx].size() > 0 ? 32'd2 : 32'd0) | (mq[idx].size() > 1 ? 32'd4 : 32'd0);
          end
          4: begin exp_tag = "R5"; exp_rd = 32'(mcfg[idx]); end
          6: begin exp_tag = "R6"; if (idx == 0) exp_rd = 32'(model_pend()); end
          default: ;
        endcase
        if (bank == 1 && mq[idx].size() > 0) void'(mq[idx].pop_front());
      end
      for (int c = 0; c < N; c++) begin
        if (ch_done[c]) begin
          if (mq[c].size() < 2) mq[c].push_back({ch_err[c], ch_flush[c], ch_last[c]});
          else begin
            logic [2:0] t;
            t = mq[c].pop_back();
            mq[c].push_back(t | 3'b100);
          end
        end
      end
      if (bus_sel && bus_we && bank == 4) mcfg[idx] = bus_wdata[1:0];
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      chk("R7 irq_o", 32'(irq_o), 32'(|model_pend()));
      chk("R6 irq_pend", 32'(irq_pend), 32'(model_pend()));
      chk("R10 rd_valid", 32'(rd_valid), 32'(exp_rv));
      if (exp_rv) chk({exp_tag, " rd_data"}, rd_data, exp_rd);
    end
  end

  task automatic do_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = rd_data;
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic pulse(input int c, input logic e, input logic f, input logic l);
    @(negedge clk);
    ch_done[c] = 1'b1; ch_err[c] = e; ch_flush[c] = f; ch_last[c] = l;
    @(negedge clk);
    ch_done = '0; ch_err = '0; ch_flush = '0; ch_last = '0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_on = 1'b1;

    // R1 reset state
    chk("R1 irq_o", 32'(irq_o), 0);
    chk("R1 irq_pend", 32'(irq_pend), 0);
    do_read(12'h044, d); chk("R1 result ch1", d, 0);
    do_read(12'h104, d); chk("R1 config ch1", d, 0);

    // Normal completion on ch3
    do_write(12'h10C, 32'd1);
    pulse(3, 1'b0, 1'b0, 1'b1);
    chk("R7 irq after done", 32'(irq_o), 1);
    do_read(12'h0CC, d); chk("R4 status ch3", d, 32'h2);
    do_read(12'h180, d); chk("R6 summary", d, 32'h8);
    chk("R4 status read no side effect", 32'(irq_o), 1);
    do_read(12'h04C, d); chk("R2 result ch3", d, 32'h8000_0002);
    chk("R3 irq cleared by read", 32'(irq_o), 0);
    do_read(12'h0CC, d); chk("R3 status cleared", d, 0);

    // Flush gating on ch5
    do_write(12'h114, 32'd1);
    pulse(5, 1'b0, 1'b1, 1'b0);
    chk("R6 flush needs flush enable", 32'(irq_o), 0);
    do_write(12'h114, 32'd3);
    chk("R6 flush enable raises", 32'(irq_o), 1);
    do_write(12'h114, 32'd0);
    chk("R5 masked", 32'(irq_o), 0);
    do_read(12'h0D4, d); chk("R5 mask keeps result", d, 32'h2);
    do_read(12'h114, d); chk("R5 config readback", d, 0);
    do_read(12'h054, d); chk("R2 flushed result", d, 32'h8000_0004);

    // Queue and overflow on ch7
    do_write(12'h11C, 32'd1);
    pulse(7, 1'b0, 1'b0, 1'b1);
    pulse(7, 1'b0, 1'b0, 1'b1);
    pulse(7, 1'b0, 1'b0, 1'b1);
    do_read(12'h0DC, d); chk("R8 status two held", d, 32'h6);
    do_read(12'h05C, d); chk("R8 first result", d, 32'h8000_0002);
    chk("R3 promoted result keeps irq", 32'(irq_o), 1);
    do_read(12'h05C, d); chk("R8 dropped arrival marks error", d, 32'h8000_000A);
    do_read(12'h05C, d); chk("R3 empty after drain", d, 0);
    chk("R7 irq low after drain", 32'(irq_o), 0);

    // Simultaneous done and read on ch9
    do_write(12'h124, 32'd1);
    pulse(9, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    ch_done[9] = 1'b1; ch_err[9] = 1'b1;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 12'h064;
    @(negedge clk);
    ch_done = '0; ch_err = '0; bus_sel = 1'b0;
    chk("R9 read returns older", rd_data, 32'h8000_0002);
    chk("R9 new result held", 32'(irq_o), 1);
    do_read(12'h064, d); chk("R9 new result", d, 32'h8000_0008);

    // Unmapped read and ignored writes
    do_read(12'h1F0, d); chk("R10 unmapped read", d, 0);
    pulse(9, 1'b0, 1'b0, 1'b1);
    do_write(12'h064, 32'hFFFF_FFFF);
    do_write(12'h180, 32'hFFFF_FFFF);
    do_read(12'h0E4, d); chk("R10 write to result ignored", d, 32'h2);
    do_read(12'h064, d); chk("R10 result intact", d, 32'h8000_0002);

    // Random traffic, compared on every clock
    for (int k = 0; k < 3000; k++) begin
      int op, c;
      @(negedge clk);
      ch_done  = N'($urandom & $urandom & $urandom);
      ch_err   = N'($urandom);
      ch_flush = N'($urandom);
      ch_last  = N'($urandom);
      op = int'($urandom % 8);
      c  = int'($urandom % N);
      bus_sel = 1'b1; bus_we = 1'b0;
      case (op)
        0, 1, 2: bus_addr = 12'(12'h040 + 4 * c);
        3:       bus_addr = 12'(12'h0C0 + 4 * c);
        4:       bus_addr = 12'(12'h100 + 4 * c);
        5:       bus_addr = 12'h180;
        6: begin
          bus_we = 1'b1;
          bus_addr = 12'(12'h100 + 4 * c);
          bus_wdata = $urandom;
        end
        default: bus_sel = 1'b0;
      endcase
    end
    @(negedge clk);
    ch_done = '0; bus_sel = 1'b0; bus_we = 1'b0;
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule